// File: doc/BRIEF.md
# MMIO Window to Partition Lookup

This block turns an incoming memory-mapped I/O address into a partition number. It holds a table of programmable address windows. Each window is a power-of-two range described by a base and mask pair, together with an enable bit, a mapping mode, a segment-count selector and a partition number. A one-cycle write port loads a whole window entry at once. A lookup port accepts a valid-qualified address and answers on the next clock with a hit flag, the partition number and the index of the winning window.

A window maps its range in one of three ways. In the first, the range is cut into as many equal slices as there are partitions, and slice n goes to partition n. In the second, the whole range goes to one programmed partition. In the third, the range is cut into 8, 64 or 128 slices, and slice n goes to partition n plus an aligned base. Each entry is checked for legality when it is written. An illegal entry sets a sticky configuration-error output and is stored as dead.

Top module: `mmio_pe_lookup`

## Requirements
- R1: An entry that is live matches an address when (addr & mask) == base. The window size is 2^k, where k is the number of trailing zero bits of the mask. The response carries rsp_hit=1 and the entry index on rsp_win.
- R2: Mode 0 (wr_mode=2'd0) splits the window into 2^PE_W slices. The partition number is address bits [k-1:k-PE_W], and the wr_pe field is ignored.
- R3: Mode 1 (wr_mode=2'd1) maps the whole window to wr_pe. A window of 2^SINGLE_MIN_LOG2 bytes (32 MB by default) or larger is legal and does not raise cfg_err.
- R4: A mode 1 entry that is enabled and smaller than 32 MB sets cfg_err. The flag then stays set until reset, and the entry never hits.
- R5: Mode 2 (wr_mode=2'd2) splits the window into 8, 64 or 128 slices, chosen by wr_segs = 0, 1 or 2. The partition number is wr_pe plus the slice index, where the slice index is the address bits just below bit k.
- R6: A mode 2 entry that is enabled raises cfg_err and never hits in any of these cases: wr_pe is not a multiple of the slice count, wr_segs=3, or the window is smaller than the slice count in bytes.
- R7: An entry written with wr_on=0, or with mode 3 (reserved), never hits and does not change cfg_err.
- R8: When several live entries match an address, the entry with the lowest index wins.
- R9: A lookup that matches no live entry returns rsp_hit=0, rsp_pe=0 and rsp_win=0.
- R10: rsp_valid is high exactly one cycle after lk_valid. A write in the same cycle as a lookup is not seen by that lookup, but it is seen by a lookup in the next cycle.
- R11: After reset every entry is dead, cfg_err=0 and rsp_valid=0.
- R12: A mode 0 entry that is enabled and whose window is smaller than 2^PE_W bytes raises cfg_err and never hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write one window entry |
| wr_idx | input | WIN_W | Index of the entry to write |
| wr_base | input | ADDR_W | Window base address |
| wr_mask | input | ADDR_W | Window mask (contiguous high ones) |
| wr_on | input | 1 | Entry enable |
| wr_mode | input | 2 | 0 full slicing, 1 single partition, 2 reduced slicing, 3 reserved |
| wr_segs | input | 2 | Reduced slice count: 0=8, 1=64, 2=128, 3 illegal |
| wr_pe | input | PE_W | Target partition (mode 1) or base partition (mode 2) |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | ADDR_W | Lookup address |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_hit | output | 1 | A live window matched |
| rsp_pe | output | PE_W | Partition number |
| rsp_win | output | WIN_W | Index of the winning window |
| cfg_err | output | 1 | Sticky illegal-entry flag |

## Verification
The legality check, the shift amount and the slice mask are worked out once, when an entry is written. A wrong value stored for any of them is not visible at that moment. It shows up only on the first lookup that lands in the window, one clock later, as a wrong rsp_pe or as a spurious hit or miss. For this reason each mode is probed at the low and high ends of a window, so that a shift that is off by one bit gives a different partition number. Priority and same-cycle write ordering are checked with overlapping windows, so that the answer differs according to which entry the block believes is live.

// File: rtl/mpl_pkg.sv
package mpl_pkg;
   typedef enum logic [1:0] {
      MODE_FULL    = 2'd0,
      MODE_SINGLE  = 2'd1,
      MODE_REDUCED = 2'd2,
      MODE_RSVD    = 2'd3
   } win_mode_e;

   typedef enum logic [1:0] {
      SEG_8    = 2'd0,
      SEG_64   = 2'd1,
      SEG_128  = 2'd2,
      SEG_RSVD = 2'd3
   } seg_sel_e;
endpackage

// File: rtl/mpl_decode.sv
// Turns raw write fields into the stored lookup form and judges legality.
module mpl_decode #(
   parameter int ADDR_W          = 40,
   parameter int PE_W            = 8,
   parameter int SINGLE_MIN_LOG2 = 25,
   parameter int SH_W            = 6
) (
   input  logic              wr_on,
   input  logic [1:0]        wr_mode,
   input  logic [1:0]        wr_segs,
   input  logic [ADDR_W-1:0] wr_mask,
   input  logic [PE_W-1:0]   wr_pe,
   output logic              d_live,
   output logic              d_err,
   output logic [SH_W-1:0]   d_shamt,
   output logic [PE_W-1:0]   d_segmsk,
   output logic [PE_W-1:0]   d_pebase
);
   import mpl_pkg::*;

   logic [SH_W-1:0] tz;
   logic [SH_W-1:0] seg_log;
   logic            legal;
   logic            rsvd;

   always_comb begin
      tz = SH_W'(ADDR_W);
      for (int b = ADDR_W - 1; b >= 0; b--) begin
         if (wr_mask[b]) tz = SH_W'(b);
      end
      seg_log  = '0;
      legal    = 1'b0;
      rsvd     = 1'b0;
      d_segmsk = '0;
      d_pebase = '0;
      case (win_mode_e'(wr_mode))
         MODE_FULL: begin
            seg_log  = SH_W'(PE_W);
            d_segmsk = '1;
            legal    = (tz >= seg_log);
         end
         MODE_SINGLE: begin
            d_pebase = wr_pe;
            legal    = (tz >= SH_W'(SINGLE_MIN_LOG2));
         end
         MODE_REDUCED: begin
            d_pebase = wr_pe;
            case (seg_sel_e'(wr_segs))
               SEG_8:   begin seg_log = SH_W'(3); d_segmsk = PE_W'(7);   end
               SEG_64:  begin seg_log = SH_W'(6); d_segmsk = PE_W'(63);  end
               SEG_128: begin seg_log = SH_W'(7); d_segmsk = PE_W'(127); end
               default: begin seg_log = '0;       d_segmsk = '0;         end
            endcase
            legal = (wr_segs != SEG_RSVD) && (tz >= seg_log)
                    && ((wr_pe & d_segmsk) == '0);
         end
         default: rsvd = 1'b1;
      endcase
      d_shamt = legal ? (tz - seg_log) : '0;
      d_live  = wr_on & legal & ~rsvd;
      d_err   = wr_on & ~legal & ~rsvd;
   end
endmodule

// File: rtl/mpl_table.sv
// Window entry storage, one register set per entry.
module mpl_table #(
   parameter int ADDR_W  = 40,
   parameter int PE_W    = 8,
   parameter int NUM_WIN = 16,
   parameter int WIN_W   = 4,
   parameter int SH_W    = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [WIN_W-1:0]  wr_idx,
   input  logic [ADDR_W-1:0] wr_base,
   input  logic [ADDR_W-1:0] wr_mask,
   input  logic              d_live,
   input  logic              d_err,
   input  logic [SH_W-1:0]   d_shamt,
   input  logic [PE_W-1:0]   d_segmsk,
   input  logic [PE_W-1:0]   d_pebase,
   output logic [NUM_WIN-1:0] live_q,
   output logic [ADDR_W-1:0] base_q   [NUM_WIN],
   output logic [ADDR_W-1:0] mask_q   [NUM_WIN],
   output logic [SH_W-1:0]   shamt_q  [NUM_WIN],
   output logic [PE_W-1:0]   segmsk_q [NUM_WIN],
   output logic [PE_W-1:0]   pebase_q [NUM_WIN]
);
   logic [NUM_WIN-1:0] sel;

   for (genvar i = 0; i < NUM_WIN; i++) begin : g_ent
      assign sel[i] = wr_en && (wr_idx == WIN_W'(i));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            live_q[i]   <= 1'b0;
            base_q[i]   <= '0;
            mask_q[i]   <= '0;
            shamt_q[i]  <= '0;
            segmsk_q[i] <= '0;
            pebase_q[i] <= '0;
         end else if (sel[i]) begin
            live_q[i]   <= d_live;
            base_q[i]   <= wr_base & wr_mask;
            mask_q[i]   <= wr_mask;
            shamt_q[i]  <= d_shamt;
            segmsk_q[i] <= d_segmsk;
            pebase_q[i] <= d_pebase;
         end
      end
   end

   // An entry written with an illegal configuration is dead afterwards.
   assert_err_entry_dead_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && d_err) |=> ((live_q & $past(sel)) == '0));
endmodule

// File: rtl/mpl_match.sv
// Per-entry compare and partition computation, then lowest-index priority.
module mpl_match #(
   parameter int ADDR_W  = 40,
   parameter int PE_W    = 8,
   parameter int NUM_WIN = 16,
   parameter int WIN_W   = 4,
   parameter int SH_W    = 6
) (
   input  logic [ADDR_W-1:0]  addr,
   input  logic [NUM_WIN-1:0] live_q,
   input  logic [ADDR_W-1:0]  base_q   [NUM_WIN],
   input  logic [ADDR_W-1:0]  mask_q   [NUM_WIN],
   input  logic [SH_W-1:0]    shamt_q  [NUM_WIN],
   input  logic [PE_W-1:0]    segmsk_q [NUM_WIN],
   input  logic [PE_W-1:0]    pebase_q [NUM_WIN],
   output logic               m_hit,
   output logic [PE_W-1:0]    m_pe,
   output logic [WIN_W-1:0]   m_win
);
   logic [NUM_WIN-1:0] hit_v;
   logic [PE_W-1:0]    pe_v [NUM_WIN];

   for (genvar i = 0; i < NUM_WIN; i++) begin : g_cmp
      logic [ADDR_W-1:0] off;
      logic [ADDR_W-1:0] slice;
      assign off      = addr & ~mask_q[i];
      assign slice    = off >> shamt_q[i];
      assign hit_v[i] = live_q[i] && ((addr & mask_q[i]) == base_q[i]);
      assign pe_v[i]  = pebase_q[i] | (slice[PE_W-1:0] & segmsk_q[i]);
   end

   always_comb begin
      m_hit = 1'b0;
      m_pe  = '0;
      m_win = '0;
      for (int i = NUM_WIN - 1; i >= 0; i--) begin
         if (hit_v[i]) begin
            m_hit = 1'b1;
            m_pe  = pe_v[i];
            m_win = WIN_W'(i);
         end
      end
   end
endmodule

// File: rtl/mmio_pe_lookup.sv
module mmio_pe_lookup #(
   parameter int ADDR_W          = 40,
   parameter int PE_W            = 8,
   parameter int NUM_WIN         = 16,
   parameter int SINGLE_MIN_LOG2 = 25,
   parameter int WIN_W           = $clog2(NUM_WIN),
   parameter int SH_W            = $clog2(ADDR_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [WIN_W-1:0]  wr_idx,
   input  logic [ADDR_W-1:0] wr_base,
   input  logic [ADDR_W-1:0] wr_mask,
   input  logic              wr_on,
   input  logic [1:0]        wr_mode,
   input  logic [1:0]        wr_segs,
   input  logic [PE_W-1:0]   wr_pe,
   input  logic              lk_valid,
   input  logic [ADDR_W-1:0] lk_addr,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic [PE_W-1:0]   rsp_pe,
   output logic [WIN_W-1:0]  rsp_win,
   output logic              cfg_err
);
   // Elaboration-time parameter checks.
   if (PE_W < 7) begin : g_chk_pe
      $error("PE_W must hold a 128-slice index");
   end
   if (ADDR_W < SINGLE_MIN_LOG2 || ADDR_W < PE_W) begin : g_chk_addr
      $error("ADDR_W too narrow for the configured windows");
   end
   if (NUM_WIN < 2) begin : g_chk_win
      $error("NUM_WIN must be at least 2");
   end

   logic              d_live, d_err;
   logic [SH_W-1:0]   d_shamt;
   logic [PE_W-1:0]   d_segmsk, d_pebase;
   logic [NUM_WIN-1:0] live_q;
   logic [ADDR_W-1:0] base_q   [NUM_WIN];
   logic [ADDR_W-1:0] mask_q   [NUM_WIN];
   logic [SH_W-1:0]   shamt_q  [NUM_WIN];
   logic [PE_W-1:0]   segmsk_q [NUM_WIN];
   logic [PE_W-1:0]   pebase_q [NUM_WIN];
   logic              m_hit;
   logic [PE_W-1:0]   m_pe;
   logic [WIN_W-1:0]  m_win;

   mpl_decode #(.ADDR_W(ADDR_W), .PE_W(PE_W), .SINGLE_MIN_LOG2(SINGLE_MIN_LOG2),
                .SH_W(SH_W)) u_dec (
      .wr_on(wr_on), .wr_mode(wr_mode), .wr_segs(wr_segs), .wr_mask(wr_mask),
      .wr_pe(wr_pe), .d_live(d_live), .d_err(d_err), .d_shamt(d_shamt),
      .d_segmsk(d_segmsk), .d_pebase(d_pebase));

   mpl_table #(.ADDR_W(ADDR_W), .PE_W(PE_W), .NUM_WIN(NUM_WIN), .WIN_W(WIN_W),
               .SH_W(SH_W)) u_tab (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_base(wr_base), .wr_mask(wr_mask), .d_live(d_live), .d_err(d_err),
      .d_shamt(d_shamt), .d_segmsk(d_segmsk), .d_pebase(d_pebase),
      .live_q(live_q), .base_q(base_q), .mask_q(mask_q), .shamt_q(shamt_q),
      .segmsk_q(segmsk_q), .pebase_q(pebase_q));

   mpl_match #(.ADDR_W(ADDR_W), .PE_W(PE_W), .NUM_WIN(NUM_WIN), .WIN_W(WIN_W),
               .SH_W(SH_W)) u_mat (
      .addr(lk_addr), .live_q(live_q), .base_q(base_q), .mask_q(mask_q),
      .shamt_q(shamt_q), .segmsk_q(segmsk_q), .pebase_q(pebase_q),
      .m_hit(m_hit), .m_pe(m_pe), .m_win(m_win));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_pe    <= '0;
         rsp_win   <= '0;
         cfg_err   <= 1'b0;
      end else begin
         rsp_valid <= lk_valid;
         rsp_hit   <= lk_valid & m_hit;
         rsp_pe    <= (lk_valid & m_hit) ? m_pe : '0;
         rsp_win   <= (lk_valid & m_hit) ? m_win : '0;
         if (wr_en && d_err) cfg_err <= 1'b1;
      end
   end

   assert_rsp_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (rsp_valid == $past(lk_valid)));
   assert_no_hit_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> !rsp_hit);
   assert_miss_zeroes_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_hit) |-> (rsp_pe == '0 && rsp_win == '0));
   assert_err_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |=> cfg_err);
   assert_reserved_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_err && wr_en && (!wr_on || wr_mode == 2'd3)) |=> !cfg_err);
endmodule

// File: tb/mmio_pe_lookup_test.sv
`timescale 1ns/1ps
module mmio_pe_lookup_test;
   localparam int ADDR_W = 40;
   localparam int PE_W   = 8;
   localparam int WIN_W  = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [WIN_W-1:0]  wr_idx = '0;
   logic [ADDR_W-1:0] wr_base = '0;
   logic [ADDR_W-1:0] wr_mask = '0;
   logic              wr_on = 1'b0;
   logic [1:0]        wr_mode = '0;
   logic [1:0]        wr_segs = '0;
   logic [PE_W-1:0]   wr_pe = '0;
   logic              lk_valid = 1'b0;
   logic [ADDR_W-1:0] lk_addr = '0;
   logic              rsp_valid, rsp_hit, cfg_err;
   logic [PE_W-1:0]   rsp_pe;
   logic [WIN_W-1:0]  rsp_win;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   typedef struct packed {
      logic             hit;
      logic [PE_W-1:0]  pe;
      logic [WIN_W-1:0] win;
   } exp_t;
   exp_t   exp_q[$];
   string  tag_q[$];

   always #10 clk = ~clk;

   mmio_pe_lookup uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_base(wr_base), .wr_mask(wr_mask), .wr_on(wr_on), .wr_mode(wr_mode),
      .wr_segs(wr_segs), .wr_pe(wr_pe), .lk_valid(lk_valid), .lk_addr(lk_addr),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_pe(rsp_pe),
      .rsp_win(rsp_win), .cfg_err(cfg_err));

   // Monitor: pops one expected item per response.
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         exp_t e;
         string t;
         n_cmp++;
         if (exp_q.size() == 0) begin
            n_bad++;
            $display("FAIL R10: unexpected response hit=%0d pe=%0h win=%0d, expected none",
                     rsp_hit, rsp_pe, rsp_win);
         end else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (rsp_hit !== e.hit || rsp_pe !== e.pe || rsp_win !== e.win) begin
               n_bad++;
               $display("FAIL %s: got hit=%0d pe=%0h win=%0d, expected hit=%0d pe=%0h win=%0d",
                        t, rsp_hit, rsp_pe, rsp_win, e.hit, e.pe, e.win);
            end
         end
      end
   end

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string t);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0h, expected %0h", t, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      wr_en = 1'b0;
      lk_valid = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wr(input int idx, input logic [ADDR_W-1:0] b, input logic [ADDR_W-1:0] m,
                     input logic on, input logic [1:0] md, input logic [1:0] sg,
                     input logic [PE_W-1:0] p);
      @(negedge clk);
      wr_en = 1'b1; wr_idx = WIN_W'(idx); wr_base = b; wr_mask = m;
      wr_on = on; wr_mode = md; wr_segs = sg; wr_pe = p;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic lk(input logic [ADDR_W-1:0] a, input logic h, input logic [PE_W-1:0] p,
                     input int w, input string t);
      @(negedge clk);
      lk_valid = 1'b1;
      lk_addr = a;
      exp_q.push_back({h, p, WIN_W'(w)});
      tag_q.push_back(t);
   endtask

   task automatic idle();
      @(negedge clk);
      lk_valid = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL R10: watchdog expired, got running, expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      do_reset();
      // R11: reset state
      chk(32'(rsp_valid), 0, "R11 rsp_valid after reset");
      chk(32'(cfg_err), 0, "R11 cfg_err after reset");
      lk(40'h00_1230_0000, 1'b0, 8'h00, 0, "R11 empty table miss");
      idle();

      // R2: full slicing, 1 MB window, slice bits [19:12]
      wr(2, 40'h00_1230_0000, 40'hFF_FFF0_0000, 1'b1, 2'd0, 2'd0, 8'h55);
      // R3: single partition, 32 MB
      wr(5, 40'h04_0000_0000, 40'hFF_FE00_0000, 1'b1, 2'd1, 2'd0, 8'h3C);
      // R5: reduced 64 slices, 64 KB, base 0x40
      wr(7, 40'h08_0001_0000, 40'hFF_FFFF_0000, 1'b1, 2'd2, 2'd1, 8'h40);
      // R5: reduced 8 slices, 4 KB, base 0xF8
      wr(8, 40'h09_0000_0000, 40'hFF_FFFF_F000, 1'b1, 2'd2, 2'd0, 8'hF8);
      // R5: reduced 128 slices, 1 MB, base 0x80
      wr(9, 40'h0A_0000_0000, 40'hFF_FFF0_0000, 1'b1, 2'd2, 2'd2, 8'h80);
      chk(32'(cfg_err), 0, "R3 legal entries leave cfg_err clear");

      lk(40'h00_123A_B456, 1'b1, 8'hAB, 2, "R2 mid slice");
      lk(40'h00_1230_0010, 1'b1, 8'h00, 2, "R2 first slice");
      lk(40'h00_123F_FFFF, 1'b1, 8'hFF, 2, "R2 last slice");
      lk(40'h04_0000_0000, 1'b1, 8'h3C, 5, "R3 window low end");
      lk(40'h04_01FF_FFFF, 1'b1, 8'h3C, 5, "R3 window high end");
      lk(40'h04_0200_0000, 1'b0, 8'h00, 0, "R1 just past window");
      lk(40'h08_0001_8C00, 1'b1, 8'h63, 7, "R5 64 slices");
      lk(40'h09_0000_0E00, 1'b1, 8'hFF, 8, "R5 8 slices");
      lk(40'h0A_000F_E000, 1'b1, 8'hFF, 9, "R5 128 slices top");
      lk(40'h0A_0000_2000, 1'b1, 8'h81, 9, "R5 128 slices one");
      lk(40'h30_0000_0000, 1'b0, 8'h00, 0, "R9 unmapped address");
      idle();

      // R4: single partition smaller than 32 MB
      wr(6, 40'h05_0000_0000, 40'hFF_FF00_0000, 1'b1, 2'd1, 2'd0, 8'h07);
      chk(32'(cfg_err), 1, "R4 small single sets cfg_err");
      lk(40'h05_0000_0100, 1'b0, 8'h00, 0, "R4 small single never hits");
      idle();
      wr(11, 40'h06_0000_0000, 40'hFF_FE00_0000, 1'b1, 2'd1, 2'd0, 8'h01);
      chk(32'(cfg_err), 1, "R4 cfg_err stays set");

      // R11: reset clears entries and the flag
      do_reset();
      chk(32'(cfg_err), 0, "R11 cfg_err cleared by reset");
      lk(40'h04_0000_0000, 1'b0, 8'h00, 0, "R11 entries dead after reset");
      idle();

      // R6: misaligned base partition
      wr(10, 40'h0B_0000_0000, 40'hFF_FFFF_0000, 1'b1, 2'd2, 2'd1, 8'h20);
      chk(32'(cfg_err), 1, "R6 misaligned base sets cfg_err");
      lk(40'h0B_0000_0400, 1'b0, 8'h00, 0, "R6 misaligned entry never hits");
      idle();
      do_reset();
      wr(10, 40'h0B_0000_0000, 40'hFF_FFFF_0000, 1'b1, 2'd2, 2'd3, 8'h00);
      chk(32'(cfg_err), 1, "R6 reserved slice count sets cfg_err");
      do_reset();
      // R12: full slicing window of 128 bytes
      wr(4, 40'h0D_0000_0000, 40'hFF_FFFF_FF80, 1'b1, 2'd0, 2'd0, 8'h00);
      chk(32'(cfg_err), 1, "R12 tiny full window sets cfg_err");
      lk(40'h0D_0000_0010, 1'b0, 8'h00, 0, "R12 tiny window never hits");
      idle();
      do_reset();

      // R7: reserved mode and disabled entries
      wr(3, 40'h04_0000_0000, 40'hFF_FE00_0000, 1'b1, 2'd3, 2'd0, 8'h12);
      wr(4, 40'h05_0000_0000, 40'hFF_FE00_0000, 1'b0, 2'd1, 2'd0, 8'h13);
      chk(32'(cfg_err), 0, "R7 reserved/disabled leave cfg_err clear");
      lk(40'h04_0000_0040, 1'b0, 8'h00, 0, "R7 reserved mode never hits");
      lk(40'h05_0000_0040, 1'b0, 8'h00, 0, "R7 disabled entry never hits");
      idle();

      // R8: overlapping windows, lowest index wins
      wr(1, 40'h0C_0000_0000, 40'hFF_FE00_0000, 1'b1, 2'd1, 2'd0, 8'h22);
      wr(3, 40'h0C_0000_0000, 40'hFF_FC00_0000, 1'b1, 2'd1, 2'd0, 8'h11);
      lk(40'h0C_0000_0100, 1'b1, 8'h22, 1, "R8 lower index wins");
      lk(40'h0C_0200_0100, 1'b1, 8'h11, 3, "R1 only wider window covers");
      idle();

      // R10: same-cycle disable not seen, next cycle seen
      @(negedge clk);
      wr_en = 1'b1; wr_idx = 4'd1; wr_on = 1'b0; wr_mode = 2'd1;
      wr_base = 40'h0C_0000_0000; wr_mask = 40'hFF_FE00_0000; wr_pe = 8'h22;
      lk_valid = 1'b1; lk_addr = 40'h0C_0000_0100;
      exp_q.push_back({1'b1, 8'h22, 4'd1}); tag_q.push_back("R10 same-cycle write unseen");
      @(negedge clk);
      wr_en = 1'b0;
      exp_q.push_back({1'b1, 8'h11, 4'd3}); tag_q.push_back("R10 next-cycle write seen");
      @(negedge clk);
      lk_valid = 1'b0;
      @(negedge clk);
      chk(32'(rsp_valid), 0, "R10 rsp_valid drops after request");
      chk(32'(exp_q.size()), 0, "R10 every request answered");

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule